// File: doc/BRIEF.md
# Serial Byte Transmitter with Hardware Break Generator

This block sends bytes on a single-wire serial line for the controlling node of a low-speed automotive bus. Software hands over one byte at a time with a write strobe. The block then sends it as an ordinary asynchronous character: a low start bit, eight data bits with the least significant bit first, and a high stop bit. On a separate request, the block instead holds the line low for a programmable number of bit times. This low field marks the start of a message on the bus. After the low field, the block drives one high bit time as a delimiter.

Every bit boundary falls on a one-cycle baud tick input, which is the only timing source. The block never inserts gaps between fields. Software sends the break, then the sync byte 55h, then the identifier, data and checksum bytes, one request at a time. It waits for the completion interrupt before each new request. A wakeup is sent as the ordinary byte 80h. The interrupt is a one-cycle pulse. It fires on the cycle the block goes idle, after data bytes and after breaks alike. Dropping the enable input aborts any transfer silently and parks the line high.

Top module: `lin_brk_tx`

## Requirements
- R1: After reset, and whenever the block is idle, `txd` is 1, `busy` is 0 and `tx_irq` is 0.
- R2: An accepted `wr_stb` sends a data frame. The first baud tick after acceptance starts the start bit (0). The following ticks start data bits 0 through 7 in order, then the stop bit (1). Each bit lasts from one tick to the next.
- R3: An accepted `brk_req` latches `brk_len` as an unsigned value n. The line is then low from the first tick after acceptance for 13+n tick intervals (000 gives 13, 111 gives 20). One high delimiter interval follows.
- R4: At the tick that ends the stop bit or the delimiter, `busy` falls. On that same cycle `tx_irq` is 1 for exactly one clock. `tx_irq` is never 1 at any other time.
- R5: `busy` rises on the cycle after an accepted request and stays 1 until the end of the frame or break.
- R6: `wr_stb` and `brk_req` are ignored while `busy` is 1. The frame in progress is unchanged and no further frame follows it.
- R7: While `tx_en` is 0, `txd` is 1, `busy` is 0, no interrupt fires and requests are ignored. Dropping `tx_en` in mid-frame aborts the frame on the next cycle, with no interrupt.
- R8: When `wr_stb` and `brk_req` are both asserted in the same accepting cycle, a break is sent.
- R9: `txd` changes only on a clock edge where `baud_tick` is 1, or where `tx_en` is 0.
- R10: The bytes 55h (sync) and 80h (wakeup) are sent as ordinary data frames, with the bit order of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable; low aborts and idles |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| wr_stb | input | 1 | Request to send `wr_data` |
| wr_data | input | 8 | Byte to send |
| brk_req | input | 1 | Request to send a break field |
| brk_len | input | 3 | Break length code, 13+n bit times |
| txd | output | 1 | Serial line, idle high |
| busy | output | 1 | Transfer in progress |
| tx_irq | output | 1 | One-cycle completion pulse |

## Verification
The hardest cases to reach from the ports are a request that arrives in the middle of a frame and an enable drop partway through one. Both must leave no trace. The bench asserts both request strobes in a cycle with no tick, several bits into a frame. It then checks every later bit against the expected slot sequence. After the frame ends it runs extra ticks to show that no second frame starts. For the abort case, the bench lowers `tx_en` after a few bits and counts interrupt pulses across the following ticks. The tick spacing is random throughout, so the bench can also check that the line holds steady between ticks.

// File: rtl/lin_tx_pkg.sv
package lin_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_SEND = 2'd2
  } tx_state_e;

  typedef enum logic {
    MODE_DATA  = 1'b0,
    MODE_BREAK = 1'b1
  } tx_mode_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/lin_tx_ctrl.sv
module lin_tx_ctrl
  import lin_tx_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     tx_en,
  input  logic     baud_tick,
  input  logic     wr_stb,
  input  logic     brk_req,
  input  logic     last_slot,
  output tx_mode_e mode,
  output logic     accept,
  output logic     start,
  output logic     step,
  output logic     finish,
  output logic     busy,
  output logic     irq
);
  tx_state_e state;

  always_comb begin
    accept = (state == ST_IDLE) && tx_en && (wr_stb || brk_req);
    start  = (state == ST_ARM)  && tx_en && baud_tick;
    step   = (state == ST_SEND) && tx_en && baud_tick && !last_slot;
    finish = (state == ST_SEND) && tx_en && baud_tick && last_slot;
  end

  always_ff @(posedge clk) begin
    if (rst || !tx_en) begin
      state <= ST_IDLE;
      mode  <= MODE_DATA;
      busy  <= 1'b0;
      irq   <= 1'b0;
    end else begin
      irq <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          state <= ST_ARM;
          mode  <= brk_req ? MODE_BREAK : MODE_DATA;
          busy  <= 1'b1;
        end
        ST_ARM: if (start) state <= ST_SEND;
        ST_SEND: if (finish) begin
          state <= ST_IDLE;
          busy  <= 1'b0;
          irq   <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lin_tx_bitsel.sv
module lin_tx_bitsel
  import lin_tx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int LEN_W    = 3,
  parameter int BRK_BASE = 13,
  parameter int CNT_W    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              step,
  input  tx_mode_e          mode,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LEN_W-1:0]  brk_len,
  input  logic [CNT_W-1:0]  idx,
  output logic [CNT_W-1:0]  total,
  output logic              next_bit
);
  logic [DATA_W:0]    shr;
  logic [LEN_W-1:0]   len_q;
  logic [CNT_W-1:0]   brk_total;

  always_ff @(posedge clk) begin
    if (rst) begin
      shr   <= '1;
      len_q <= '0;
    end else if (accept) begin
      shr   <= {1'b1, wr_data};
      len_q <= brk_len;
    end else if (step && mode == MODE_DATA) begin
      shr   <= {1'b1, shr[DATA_W:1]};
    end
  end

  always_comb begin
    brk_total = CNT_W'(BRK_BASE) + CNT_W'(len_q) + CNT_W'(1);
    total     = (mode == MODE_BREAK) ? brk_total : CNT_W'(DATA_W + 2);
    if (mode == MODE_BREAK)
      next_bit = ((idx + CNT_W'(1)) == (total - CNT_W'(1)));
    else
      next_bit = shr[0];
  end
endmodule

// File: rtl/lin_tx_slotcnt.sv
module lin_tx_slotcnt #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             step,
  input  logic [CNT_W-1:0] total,
  output logic [CNT_W-1:0] idx,
  output logic             last_slot
);
  always_ff @(posedge clk) begin
    if (rst)        idx <= '0;
    else if (start) idx <= '0;
    else if (step)  idx <= idx + CNT_W'(1);
  end

  assign last_slot = (idx == (total - CNT_W'(1)));
endmodule

// File: rtl/lin_brk_tx.sv
module lin_brk_tx
  import lin_tx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int LEN_W    = 3,
  parameter int BRK_BASE = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              baud_tick,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              brk_req,
  input  logic [LEN_W-1:0]  brk_len,
  output logic              txd,
  output logic              busy,
  output logic              tx_irq
);
  localparam int MAX_SLOTS = max_int(DATA_W + 2, BRK_BASE + (2**LEN_W - 1) + 1);
  localparam int CNT_W     = $clog2(MAX_SLOTS + 1);

  tx_mode_e         mode;
  logic             accept, start, step, finish, last_slot, next_bit;
  logic [CNT_W-1:0] idx, total;

  lin_tx_ctrl u_ctrl (
    .clk(clk), .rst(rst), .tx_en(tx_en), .baud_tick(baud_tick),
    .wr_stb(wr_stb), .brk_req(brk_req), .last_slot(last_slot),
    .mode(mode), .accept(accept), .start(start), .step(step),
    .finish(finish), .busy(busy), .irq(tx_irq)
  );

  lin_tx_bitsel #(
    .DATA_W(DATA_W), .LEN_W(LEN_W), .BRK_BASE(BRK_BASE), .CNT_W(CNT_W)
  ) u_bitsel (
    .clk(clk), .rst(rst), .accept(accept), .step(step), .mode(mode),
    .wr_data(wr_data), .brk_len(brk_len), .idx(idx), .total(total),
    .next_bit(next_bit)
  );

  lin_tx_slotcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .start(start), .step(step), .total(total),
    .idx(idx), .last_slot(last_slot)
  );

  always_ff @(posedge clk) begin
    if (rst || !tx_en) txd <= 1'b1;
    else if (start)    txd <= 1'b0;
    else if (step)     txd <= next_bit;
    else if (finish)   txd <= 1'b1;
  end
endmodule

// File: rtl/lin_brk_tx_chk.sv
module lin_brk_tx_chk (
  input logic clk,
  input logic rst,
  input logic tx_en,
  input logic baud_tick,
  input logic wr_stb,
  input logic brk_req,
  input logic txd,
  input logic busy,
  input logic tx_irq
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd); // R1
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tx_irq |=> !tx_irq); // R4
  AST_IRQ_AT_BUSY_FALL: assert property (@(posedge clk) disable iff (rst)
    tx_irq |-> (!busy && $past(busy))); // R4
  AST_BUSY_FALL_GIVES_IRQ: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && $past(tx_en)) |-> tx_irq); // R4
  AST_BUSY_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(tx_en && (wr_stb || brk_req))); // R5
  AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> (!busy && txd && !tx_irq)); // R7
  AST_TXD_TICK_ONLY: assert property (@(posedge clk) disable iff (rst)
    ($past(tx_en) && !$past(baud_tick)) |-> $stable(txd)); // R9
endmodule

bind lin_brk_tx lin_brk_tx_chk u_chk (
  .clk(clk), .rst(rst), .tx_en(tx_en), .baud_tick(baud_tick),
  .wr_stb(wr_stb), .brk_req(brk_req), .txd(txd), .busy(busy),
  .tx_irq(tx_irq)
);

// File: tb/sim_lin_brk_tx.sv
module sim_lin_brk_tx;
  logic clk = 1'b0, rst = 1'b1, tx_en = 1'b1, baud_tick = 1'b0;
  logic wr_stb = 1'b0, brk_req = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [2:0] brk_len = 3'd0;
  logic txd, busy, tx_irq;
  int checks = 0, errors = 0, irq_seen = 0, cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lin_brk_tx u0 (
    .clk(clk), .rst(rst), .tx_en(tx_en), .baud_tick(baud_tick),
    .wr_stb(wr_stb), .wr_data(wr_data), .brk_req(brk_req),
    .brk_len(brk_len), .txd(txd), .busy(busy), .tx_irq(tx_irq)
  );

  always @(negedge clk) if (tx_irq) irq_seen++;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_bit(bit brk, logic [7:0] d, int n, int k);
    if (brk) return (k == 13 + n);
    if (k == 0) return 1'b0;
    if (k <= 8) return d[k-1];
    return 1'b1;
  endfunction

  function automatic int exp_total(bit brk, int n);
    return brk ? 14 + n : 10;
  endfunction

  // one tick, sampled after the edge, then a random quiet gap checked for R9
  task automatic tick(output logic sampled);
    int gap;
    @(negedge clk) baud_tick = 1'b1;
    @(negedge clk) baud_tick = 1'b0;
    sampled = txd;
    gap = $urandom_range(0, 3);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      chk("R9 line steady between ticks", txd, sampled);
    end
  endtask

  task automatic request(bit wr, bit brk, logic [7:0] d, logic [2:0] n);
    @(negedge clk);
    wr_stb = wr; brk_req = brk; wr_data = d; brk_len = n;
    @(negedge clk);
    wr_stb = 1'b0; brk_req = 1'b0;
    wr_data = $urandom; brk_len = $urandom;
  endtask

  task automatic run_frame(string tag, bit wr, bit brk, logic [7:0] d,
                           logic [2:0] n, bit inject);
    logic s;
    bit is_brk = brk;
    int tot = exp_total(is_brk, int'(n));
    int irq0;
    request(wr, brk, d, n);
    chk({tag, " R5 busy after accept"}, busy, 1);
    chk({tag, " R5 line idle before first tick"}, txd, 1);
    irq0 = irq_seen;
    for (int k = 0; k < tot; k++) begin
      if (inject && k == 3) begin
        @(negedge clk);
        wr_stb = 1'b1; brk_req = 1'b1; wr_data = ~d; brk_len = 3'd7;
        @(negedge clk);
        wr_stb = 1'b0; brk_req = 1'b0;
      end
      tick(s);
      chk({tag, is_brk ? " R3 break slot" : " R2 data slot"}, s, exp_bit(is_brk, d, int'(n), k));
      chk({tag, " R5 busy mid-frame"}, busy, 1);
    end
    chk({tag, " R4 no irq mid-frame"}, irq_seen - irq0, 0);
    @(negedge clk) baud_tick = 1'b1;
    @(negedge clk) baud_tick = 1'b0;
    chk({tag, " R4 irq at end"}, tx_irq, 1);
    chk({tag, " R4 busy falls with irq"}, busy, 0);
    chk({tag, " R1 idle line"}, txd, 1);
    @(negedge clk);
    chk({tag, " R4 irq one cycle"}, tx_irq, 0);
    if (inject) begin
      for (int k = 0; k < 4; k++) begin
        tick(s);
        chk({tag, " R6 no frame after ignored request"}, busy, 0);
        chk({tag, " R6 line stays high"}, s, 1);
      end
    end
  endtask

  initial begin
    logic s;
    int irq0;
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset txd", txd, 1);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset irq", tx_irq, 0);

    run_frame("R10 sync 55h", 1, 0, 8'h55, 3'd0, 0);
    run_frame("R10 wakeup 80h", 1, 0, 8'h80, 3'd0, 0);
    run_frame("R2 all ones", 1, 0, 8'hFF, 3'd0, 0);
    run_frame("R2 all zeros", 1, 0, 8'h00, 3'd0, 0);
    for (int n = 0; n < 8; n++)
      run_frame("R3 break len", 0, 1, 8'h00, 3'(n), 0);
    run_frame("R8 both requests", 1, 1, 8'hA5, 3'd0, 0);
    run_frame("R6 data busy ignore", 1, 0, 8'h3C, 3'd0, 1);
    run_frame("R6 break busy ignore", 0, 1, 8'h00, 3'd2, 1);

    for (int i = 0; i < 24; i++) begin
      if ($urandom_range(0, 3) == 0)
        run_frame("R3 random break", 0, 1, 8'h00, 3'($urandom), 0);
      else
        run_frame("R2 random byte", 1, 0, 8'($urandom), 3'd0, 0);
    end

    // R7 abort mid-frame
    request(1, 0, 8'hC3, 3'd0);
    for (int k = 0; k < 4; k++) tick(s);
    irq0 = irq_seen;
    @(negedge clk) tx_en = 1'b0;
    @(negedge clk);
    chk("R7 abort line high", txd, 1);
    chk("R7 abort busy low", busy, 0);
    request(1, 1, 8'h00, 3'd0);
    chk("R7 request ignored while disabled", busy, 0);
    for (int k = 0; k < 12; k++) begin
      tick(s);
      chk("R7 line high while disabled", s, 1);
    end
    chk("R7 no irq on abort", irq_seen - irq0, 0);
    @(negedge clk) tx_en = 1'b1;
    for (int k = 0; k < 3; k++) tick(s);
    chk("R7 no stale frame after enable", busy, 0);
    run_frame("R7 resume after enable", 1, 0, 8'h96, 3'd0, 0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule